// File: doc/BRIEF.md
# Display Serial Video Timing Generator

This block schedules the packets of a display serial link that runs in video mode. It does not count pixel clocks. Horizontal spans are counted in lane-byte-clock cycles, and vertical spans are counted in whole lines. For every line it emits a stream of event strobes: sync starts, sync ends, the start of the pixel payload and the start of front-porch blanking. A packet assembler downstream turns these strobes into packets. The block also says, cycle by cycle, whether the link may drop to low power.

The timing set and the mode come from configuration registers. The run input acts as the power-up control: while it is low the generator is held idle, and when it goes high a new frame starts from its first line. Three mode codes are supported. Sync-pulse sends both the start and the end of every sync. Sync-event sends only the start. Burst behaves like sync-event and also sends no front-porch blanking event, so the rest of the line is free for low power.

Top module: `dsi_vid_timing`

## Requirements
- R1: While `run` is low, every output is 0 from the next clock edge onward (no strobe, `lp_ok` 0, `line_o` 0). Raising `run` restarts the frame at line 0, position 0, so the first strobe is a vertical sync start.
- R2: Each line lasts `hline_len` cycles. Every line emits a sync start at position 0. Its type is 0 (vertical sync start) on the first line of the vertical sync region and 2 (horizontal sync start) on every other line. All outputs describe the schedule position of the previous clock cycle.
- R3: In mode 0 (sync pulses), a sync end is emitted at position `hsa_len` of every line. Its type is 1 (vertical sync end) on the last line of the vertical sync region and 3 (horizontal sync end) on every other line.
- R4: In mode 1 (sync events), mode 2 (burst) and mode 3 (handled like mode 1), no sync end event of type 1 or 3 is emitted.
- R5: A frame consists of `vsa_lines` sync lines, then `vbp_lines` back-porch lines, then `vact_lines` active lines, then `vfp_lines` front-porch lines, and then it wraps. `line_o` counts from 0 up to the total minus 1 and returns to 0 at the wrap. Each count must be at least 1.
- R6: On active lines only, a payload event (type 4) is emitted at position `hsa_len + hbp_len`.
- R7: On active lines in modes other than burst, a blanking event (type 5) is emitted at position `hsa_len + hbp_len + act_len`. Burst mode emits no type 5 event.
- R8: `lp_ok` is 0 during the sync window (positions below `hsa_len`). On blanking lines at or after `hsa_len`, it follows `lp_mask` bit 0 for vertical sync lines, bit 1 for back-porch lines and bit 2 for front-porch lines. On active lines it is high only when bit 3 is set and the position is either in the back porch with bit 4 set or at or after the front-porch start with bit 5 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Power-up control: 0 holds idle, 1 runs |
| mode | input | 2 | 0 sync pulses, 1 sync events, 2 burst, 3 as 1 |
| hsa_len | input | HW | Horizontal sync width in byte cycles |
| hbp_len | input | HW | Horizontal back porch in byte cycles |
| act_len | input | HW | Payload duration in byte cycles |
| hline_len | input | HW | Whole line time in byte cycles |
| vsa_lines | input | VW | Vertical sync lines |
| vbp_lines | input | VW | Vertical back-porch lines |
| vact_lines | input | VW | Active lines |
| vfp_lines | input | VW | Vertical front-porch lines |
| lp_mask | input | 6 | Per-region low-power permission |
| ev_vld | output | 1 | Event strobe |
| ev_type | output | 3 | Event code (0..5) |
| line_o | output | VW+2 | Line number within the frame |
| lp_ok | output | 1 | Link may enter low power |

## Verification
Five timing sets are each run for one full frame, and the bench counts every event type across that frame. The sets cover all four mode codes, so the counts separate pulse mode from the event and burst modes (presence of sync ends) and burst from the other modes (presence of blanking). The frames use different region sizes, so a swapped region order or a miscounted line shows up as a wrong payload or sync count. Directed probes then sample single positions of one frame: the payload, blanking and sync end offsets, the line wrap, and the low-power flag under two masks. The last probe drops `run` in the middle of a line to check that the generator goes quiet and restarts cleanly.

// File: rtl/dsi_vid_timing.sv
module dsi_vid_timing #(
  parameter int HW = 16,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [1:0]    mode,
  input  logic [HW-1:0] hsa_len,
  input  logic [HW-1:0] hbp_len,
  input  logic [HW-1:0] act_len,
  input  logic [HW-1:0] hline_len,
  input  logic [VW-1:0] vsa_lines,
  input  logic [VW-1:0] vbp_lines,
  input  logic [VW-1:0] vact_lines,
  input  logic [VW-1:0] vfp_lines,
  input  logic [5:0]    lp_mask,
  output logic          ev_vld,
  output logic [2:0]    ev_type,
  output logic [VW+1:0] line_o,
  output logic          lp_ok
);
  localparam int LW = VW + 2;
  localparam int XW = HW + 2;
  localparam logic [2:0] T_VSS = 3'd0, T_VSE = 3'd1, T_HSS = 3'd2,
                         T_HSE = 3'd3, T_PIX = 3'd4, T_BLK = 3'd5;
  localparam logic [1:0] G_VSA = 2'd0, G_VBP = 2'd1, G_ACT = 2'd2, G_VFP = 2'd3;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [1:0]    vreg;
  logic [LW-1:0] line_q;

  logic [VW-1:0] reg_len;
  always_comb
    case (vreg)
      G_VSA:   reg_len = vsa_lines;
      G_VBP:   reg_len = vbp_lines;
      G_ACT:   reg_len = vact_lines;
      default: reg_len = vfp_lines;
    endcase

  wire last_h = (hcnt == hline_len - 1'b1);
  wire last_v = (vcnt == reg_len - 1'b1);
  wire pulse  = (mode == 2'd0);
  wire burst  = (mode == 2'd2);
  wire act_ln = (vreg == G_ACT);
  wire [XW-1:0] hx = XW'(hcnt);
  wire [XW-1:0] hb = XW'(hsa_len) + XW'(hbp_len);
  wire [XW-1:0] hf = hb + XW'(act_len);
  wire in_sync = (hx < XW'(hsa_len));

  logic       ev_n;
  logic [2:0] ty_n;
  always_comb begin
    ev_n = 1'b1;
    ty_n = T_HSS;
    if (hcnt == '0)
      ty_n = (vreg == G_VSA && vcnt == '0) ? T_VSS : T_HSS;
    else if (pulse && hcnt == hsa_len)
      ty_n = (vreg == G_VSA && last_v) ? T_VSE : T_HSE;
    else if (act_ln && hx == hb)
      ty_n = T_PIX;
    else if (act_ln && !burst && hx == hf)
      ty_n = T_BLK;
    else
      ev_n = 1'b0;
  end

  logic lp_n;
  always_comb begin
    if (in_sync) lp_n = 1'b0;
    else if (!act_ln)
      lp_n = lp_mask[(vreg == G_VSA) ? 0 : (vreg == G_VBP) ? 1 : 2];
    else
      lp_n = lp_mask[3] & (((hx < hb) & lp_mask[4]) | ((hx >= hf) & lp_mask[5]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt <= '0; vcnt <= '0; vreg <= G_VSA; line_q <= '0;
      ev_vld <= 1'b0; ev_type <= '0; line_o <= '0; lp_ok <= 1'b0;
    end else if (!run) begin
      hcnt <= '0; vcnt <= '0; vreg <= G_VSA; line_q <= '0;
      ev_vld <= 1'b0; ev_type <= '0; line_o <= '0; lp_ok <= 1'b0;
    end else begin
      ev_vld  <= ev_n;
      ev_type <= ev_n ? ty_n : 3'd0;
      line_o  <= line_q;
      lp_ok   <= lp_n;
      if (!last_h) hcnt <= hcnt + 1'b1;
      else begin
        hcnt <= '0;
        if (last_v) begin
          vcnt <= '0;
          vreg <= vreg + 1'b1;
          line_q <= (vreg == G_VFP) ? '0 : line_q + 1'b1;
        end else begin
          vcnt <= vcnt + 1'b1;
          line_q <= line_q + 1'b1;
        end
      end
    end

  wire [LW-1:0] tot_lines = LW'(vsa_lines) + LW'(vbp_lines) + LW'(vact_lines) + LW'(vfp_lines);

  // R1
  run_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!ev_vld && !lp_ok && line_o == '0));
  // R1
  restart_vss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> (ev_vld && ev_type == T_VSS));
  // R4
  no_sync_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode != 2'd0) |=> !(ev_vld && (ev_type == T_VSE || ev_type == T_HSE)));
  // R7
  burst_no_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == 2'd2) |=> !(ev_vld && ev_type == T_BLK));
  // R5
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vld |-> (line_o < tot_lines));
  // R2
  type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vld |-> (ev_type <= T_BLK));
endmodule

// File: tb/dsi_vid_timing_tb.sv
module dsi_vid_timing_tb;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [1:0] mode = '0;
  logic [15:0] hsa_len = '0, hbp_len = '0, act_len = '0, hline_len = '0;
  logic [11:0] vsa_lines = '0, vbp_lines = '0, vact_lines = '0, vfp_lines = '0;
  logic [5:0] lp_mask = '0;
  logic ev_vld, lp_ok;
  logic [2:0] ev_type;
  logic [13:0] line_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dsi_vid_timing u_dut (.clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
    .hsa_len(hsa_len), .hbp_len(hbp_len), .act_len(act_len), .hline_len(hline_len),
    .vsa_lines(vsa_lines), .vbp_lines(vbp_lines), .vact_lines(vact_lines),
    .vfp_lines(vfp_lines), .lp_mask(lp_mask), .ev_vld(ev_vld), .ev_type(ev_type),
    .line_o(line_o), .lp_ok(lp_ok));

  typedef struct packed {
    logic [1:0] md;
    logic [7:0] hsa, hbp, act, hl, vs, vb, va, vf;
    logic [7:0] n_vss, n_vse, n_hss, n_hse, n_pix, n_blk;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd0, 8'd2, 8'd3, 8'd4, 8'd14, 8'd2, 8'd1, 8'd3, 8'd2, 8'd1, 8'd1, 8'd7, 8'd7, 8'd3, 8'd3},
    '{2'd1, 8'd1, 8'd2, 8'd5, 8'd10, 8'd1, 8'd2, 8'd4, 8'd1, 8'd1, 8'd0, 8'd7, 8'd0, 8'd4, 8'd4},
    '{2'd2, 8'd3, 8'd1, 8'd2, 8'd9,  8'd3, 8'd1, 8'd2, 8'd3, 8'd1, 8'd0, 8'd8, 8'd0, 8'd2, 8'd0},
    '{2'd3, 8'd2, 8'd2, 8'd2, 8'd8,  8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd0, 8'd3, 8'd0, 8'd1, 8'd1},
    '{2'd0, 8'd1, 8'd1, 8'd1, 8'd4,  8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd3, 8'd3, 8'd1, 8'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic load(input vec_t v);
    run = 1'b0;
    step(1);
    mode = v.md;
    hsa_len = 16'(v.hsa); hbp_len = 16'(v.hbp); act_len = 16'(v.act); hline_len = 16'(v.hl);
    vsa_lines = 12'(v.vs); vbp_lines = 12'(v.vb); vact_lines = 12'(v.va); vfp_lines = 12'(v.vf);
    run = 1'b1;
  endtask

  // start frame of VECS[0] and stop at sample k (position k-1 of the frame)
  task automatic probe(input int k);
    load(VECS[0]);
    step(k);
  endtask

  initial begin
    int cnt[6];
    @(negedge clk);
    // R1 reset state
    check("R1 reset ev_vld", int'(ev_vld), 0);
    check("R1 reset line_o", int'(line_o), 0);
    rst_n = 1'b1;
    step(2);
    check("R1 idle while run low", int'(ev_vld), 0);

    foreach (VECS[i]) begin
      int cyc;
      load(VECS[i]);
      cyc = int'(VECS[i].hl) * (int'(VECS[i].vs) + int'(VECS[i].vb) + int'(VECS[i].va) + int'(VECS[i].vf));
      for (int t = 0; t < 6; t++) cnt[t] = 0;
      for (int c = 0; c < cyc; c++) begin
        step(1);
        if (ev_vld) cnt[ev_type]++;
      end
      check($sformatf("R2 vec%0d vss count", i), cnt[0], int'(VECS[i].n_vss));
      check($sformatf("R3 vec%0d vse count", i), cnt[1], int'(VECS[i].n_vse));
      check($sformatf("R5 vec%0d hss count", i), cnt[2], int'(VECS[i].n_hss));
      check($sformatf("R4 vec%0d hse count", i), cnt[3], int'(VECS[i].n_hse));
      check($sformatf("R6 vec%0d pix count", i), cnt[4], int'(VECS[i].n_pix));
      check($sformatf("R7 vec%0d blk count", i), cnt[5], int'(VECS[i].n_blk));
    end

    // VECS[0]: hsa2 hbp3 act4 line14; lines VSA0-1 VBP2 ACT3-5 VFP6-7
    probe(1);
    check("R2 first strobe type", int'(ev_vld) * 10 + int'(ev_type), 10);
    probe(17);
    check("R3 vse on last sync line", int'(ev_vld) * 10 + int'(ev_type), 11);
    probe(45);
    check("R3 hse at hsa on active line", int'(ev_vld) * 10 + int'(ev_type), 13);
    probe(48);
    check("R6 payload at hsa+hbp", int'(ev_vld) * 10 + int'(ev_type), 14);
    check("R5 line number first active", int'(line_o), 3);
    probe(52);
    check("R7 blanking at front porch", int'(ev_vld) * 10 + int'(ev_type), 15);
    probe(35);
    check("R6 no payload on back-porch line", int'(ev_vld), 0);
    probe(113);
    check("R5 wrap to line 0", int'(line_o), 0);
    check("R5 wrap vss", int'(ev_vld) * 10 + int'(ev_type), 10);

    lp_mask = 6'b000001;
    probe(6);
    check("R8 lp in sync region mask0", int'(lp_ok), 1);
    probe(2);
    check("R8 no lp in sync window", int'(lp_ok), 0);
    probe(34);
    check("R8 no lp back-porch line bit1 clear", int'(lp_ok), 0);
    lp_mask = 6'b011000;
    probe(46);
    check("R8 lp in active back porch", int'(lp_ok), 1);
    probe(53);
    check("R8 no lp in front porch bit5 clear", int'(lp_ok), 0);
    probe(49);
    check("R8 no lp in payload window", int'(lp_ok), 0);
    lp_mask = '0;

    probe(48);
    run = 1'b0;
    step(1);
    check("R1 quiet after run drop", int'(ev_vld) + int'(line_o), 0);
    run = 1'b1;
    step(1);
    check("R1 restart vss", int'(ev_vld) * 10 + int'(ev_type), 10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule